// File: doc/BRIEF.md
# PLL Control Sequencer

This block is the digital control side of an on-chip clock module. It holds the configuration that sets the CPU clock ratio: a 4-bit PLL multiplier and a 2-bit post-divider select. It also holds two status bits and one control bit: a lock indication, a sticky missing-clock (limp) flag and a switch that turns missing-clock detection off. The analog loop and the oscillator are outside the block. The block reports the ratio the CPU clock should run at as a numerator and denominator, so the input frequency times `ratio_num / ratio_div` is the CPU frequency.

Software reaches two registers through a single-cycle write port. Writes only land while a write-protect unlock input is high. The block enforces the ordering rules of a safe frequency change:
- The multiplier may only be changed while the post-divider select is zero, which is divide-by-four.
- Every accepted multiplier change starts a lock countdown. During the countdown the ratio falls back to one half of the input clock.
- A detected missing clock parks the ratio at a fixed limp value until reset.

An over-speed flag marks any ratio above the configured ceiling. With a 30 MHz input and a ceiling of 5, that ceiling is 150 MHz.

Top module: `pllctl_seq`

## Requirements
- R1: After a synchronous reset, the outputs are: multiplier 0, divider select 0, detection switch 0, limp flag 0, lock indication 1, and ratio 1/4.
- R2: A write with `wr_unlock` low has no effect on any register.
- R3: A multiplier write (`wr_sel`=0, value in `wr_data[3:0]`) is dropped while the divider select is not 0.
- R4: An accepted multiplier change drops `pll_locked` on the next cycle and holds the ratio at 1/2 for LOCK_CYCLES cycles. After that, `pll_locked` rises and the new multiplier drives the ratio. Divider-select writes during the countdown do not change the ratio.
- R5: When locked and not in limp mode, `ratio_num` is the multiplier, or 1 when the multiplier is 0. `ratio_div` is 4, 2, 2 or 1 for divider select 0, 1, 2 or 3.
- R6: A status write (`wr_sel`=1) loads the divider select from `wr_data[8:7]` and the detection switch from `wr_data[6]`.
- R7: A `miss_pulse` sets `limp_active` only while `detect_off` is 0. Once set, `limp_active` stays 1 until reset.
- R8: While `limp_active` is 1, the ratio is LIMP_NUM/LIMP_DIV (default 1/2), whatever the other settings are.
- R9: `over_speed` is 1 exactly when `ratio_num` > MAX_RATIO × `ratio_div` (MAX_RATIO default 5).
- R10: Writing the multiplier value that is already held does not restart the lock countdown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_unlock | input | 1 | Write-protect release; writes land only while high |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0 = multiplier register, 1 = status/control register |
| wr_data | input | 16 | Write data |
| miss_pulse | input | 1 | Missing-clock detection pulse |
| mult_cfg | output | 4 | Programmed multiplier |
| div_sel | output | 2 | Programmed divider select |
| detect_off | output | 1 | Missing-clock detection disabled |
| pll_locked | output | 1 | Lock countdown finished |
| limp_active | output | 1 | Sticky missing-clock flag |
| ratio_num | output | 4 | CPU clock ratio numerator |
| ratio_div | output | 3 | CPU clock ratio denominator (1, 2 or 4) |
| over_speed | output | 1 | Ratio above the MAX_RATIO ceiling |

## Verification
The assertions check the following properties on every cycle:
- Write protection and the divider-zero gate both hold the multiplier steady.
- The limp flag never clears and cannot rise while detection is off.
- The ratio is 1/2 during the lock countdown and is the limp value in limp mode.
- The denominator is always a single power of two.

Only the bench scenarios can show the rest:
- The exact length of the countdown.
- That rewriting the same multiplier does not restart it.
- The full divider-select decode and the over-speed threshold at its boundary (10/2 against 10/1 and 12/2).
- The ordering of a change: divider to zero, multiplier, wait, divider up.

// File: rtl/pllctl_pkg.sv
package pllctl_pkg;

    localparam int DATA_W   = 16;
    localparam int MULT_W   = 4;
    localparam int DSEL_W   = 2;
    localparam int DSEL_LSB = 7;
    localparam int DOFF_BIT = 6;
    localparam int RDIV_W   = 3;

    typedef enum logic {
        REG_MULT = 1'b0,
        REG_STAT = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic [MULT_W-1:0] mult;
        logic [DSEL_W-1:0] dsel;
        logic              det_off;
        logic              limp;
    } cfg_t;

    typedef struct packed {
        logic [MULT_W-1:0] num;
        logic [RDIV_W-1:0] div;
    } ratio_t;

    function automatic logic [RDIV_W-1:0] dsel_to_div(input logic [DSEL_W-1:0] s);
        logic [RDIV_W-1:0] d;
        case (s)
            2'd0:    d = 3'd4;
            2'd1:    d = 3'd2;
            2'd2:    d = 3'd2;
            default: d = 3'd1;
        endcase
        return d;
    endfunction

    function automatic logic [MULT_W-1:0] mult_to_num(input logic [MULT_W-1:0] m);
        return (m == '0) ? MULT_W'(1) : m;
    endfunction

    function automatic logic ratio_exceeds(input ratio_t r, input int unsigned ceiling);
        return int'(r.num) > int'(ceiling) * int'(r.div);
    endfunction

endpackage

// File: rtl/pllctl_regs.sv
module pllctl_regs
    import pllctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_unlock,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              miss_pulse,
    output cfg_t              cfg,
    output logic              mult_start
);

    cfg_t cfg_q;
    logic wr_ok;
    logic stat_wr;
    logic [MULT_W-1:0] mult_new;
    logic unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[DATA_W-1:DSEL_LSB+DSEL_W], wr_data[DOFF_BIT-1:MULT_W]};

    assign wr_ok    = wr_unlock && wr_en;
    assign stat_wr  = wr_ok && (wr_sel == REG_STAT);
    assign mult_new = wr_data[MULT_W-1:0];

    // Multiplier changes only from divide-by-four and only when the value differs
    assign mult_start = wr_ok && (wr_sel == REG_MULT) &&
                        (cfg_q.dsel == '0) && (mult_new != cfg_q.mult);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            if (mult_start) begin
                cfg_q.mult <= mult_new;
            end
            if (stat_wr) begin
                cfg_q.dsel    <= wr_data[DSEL_LSB +: DSEL_W];
                cfg_q.det_off <= wr_data[DOFF_BIT];
            end
            if (miss_pulse && !cfg_q.det_off) begin
                cfg_q.limp <= 1'b1;
            end
        end
    end

    assign cfg = cfg_q;

    AST_PROTECT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_unlock && wr_en) |=> ($stable(cfg_q.mult) && $stable(cfg_q.dsel) && $stable(cfg_q.det_off))); // R2

    AST_MULT_GATED: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.dsel != '0) |=> $stable(cfg_q.mult)); // R3

    AST_LIMP_STICKY: assert property (@(posedge clk) disable iff (rst)
        cfg_q.limp |=> cfg_q.limp); // R7

    AST_DETECT_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.det_off && !cfg_q.limp) |=> !cfg_q.limp); // R7

endmodule

// File: rtl/pllctl_lockctr.sv
module pllctl_lockctr #(
    parameter int unsigned LOCK_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic locked
);

    localparam int CW = $clog2(LOCK_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(LOCK_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign locked = (cnt_q == '0);

    AST_LOCK_DROP: assert property (@(posedge clk) disable iff (rst)
        start |=> !locked); // R4

    AST_LOCK_KEEP: assert property (@(posedge clk) disable iff (rst)
        (locked && !start) |=> locked); // R10

endmodule

// File: rtl/pllctl_ratio.sv
module pllctl_ratio
    import pllctl_pkg::*;
#(
    parameter int unsigned MAX_RATIO = 5,
    parameter int unsigned LIMP_NUM  = 1,
    parameter int unsigned LIMP_DIV  = 2
) (
    input  cfg_t   cfg,
    input  logic   locked,
    output ratio_t ratio,
    output logic   over
);

    ratio_t run_ratio;
    ratio_t half_ratio;
    ratio_t limp_ratio;

    assign run_ratio.num  = mult_to_num(cfg.mult);
    assign run_ratio.div  = dsel_to_div(cfg.dsel);
    assign half_ratio.num = MULT_W'(1);
    assign half_ratio.div = RDIV_W'(2);
    assign limp_ratio.num = MULT_W'(LIMP_NUM);
    assign limp_ratio.div = RDIV_W'(LIMP_DIV);

    always_comb begin
        if (cfg.limp) begin
            ratio = limp_ratio;
        end else if (!locked) begin
            ratio = half_ratio;
        end else begin
            ratio = run_ratio;
        end
    end

    assign over = ratio_exceeds(ratio, MAX_RATIO);

endmodule

// File: rtl/pllctl_seq.sv
module pllctl_seq
    import pllctl_pkg::*;
#(
    parameter int unsigned LOCK_CYCLES = 1024,
    parameter int unsigned MAX_RATIO   = 5,
    parameter int unsigned LIMP_NUM    = 1,
    parameter int unsigned LIMP_DIV    = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_unlock,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [15:0] wr_data,
    input  logic        miss_pulse,
    output logic [3:0]  mult_cfg,
    output logic [1:0]  div_sel,
    output logic        detect_off,
    output logic        pll_locked,
    output logic        limp_active,
    output logic [3:0]  ratio_num,
    output logic [2:0]  ratio_div,
    output logic        over_speed
);

    cfg_t   cfg;
    ratio_t ratio;
    logic   mult_start;
    logic   locked;
    logic   over;

    pllctl_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_unlock  (wr_unlock),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .miss_pulse (miss_pulse),
        .cfg        (cfg),
        .mult_start (mult_start)
    );

    pllctl_lockctr #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk    (clk),
        .rst    (rst),
        .start  (mult_start),
        .locked (locked)
    );

    pllctl_ratio #(
        .MAX_RATIO (MAX_RATIO),
        .LIMP_NUM  (LIMP_NUM),
        .LIMP_DIV  (LIMP_DIV)
    ) u_ratio (
        .cfg    (cfg),
        .locked (locked),
        .ratio  (ratio),
        .over   (over)
    );

    assign mult_cfg    = cfg.mult;
    assign div_sel     = cfg.dsel;
    assign detect_off  = cfg.det_off;
    assign limp_active = cfg.limp;
    assign pll_locked  = locked;
    assign ratio_num   = ratio.num;
    assign ratio_div   = ratio.div;
    assign over_speed  = over;

    AST_LOCK_HALF: assert property (@(posedge clk) disable iff (rst)
        (!pll_locked && !limp_active) |-> (ratio_num == 4'd1 && ratio_div == 3'd2)); // R4

    AST_DIV_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(ratio_div) == 1); // R5

    AST_LIMP_FORCE: assert property (@(posedge clk) disable iff (rst)
        limp_active |-> (ratio_num == 4'(LIMP_NUM) && ratio_div == 3'(LIMP_DIV))); // R8

endmodule

// File: tb/pllctl_seq_tb.sv
module pllctl_seq_tb_top;

    localparam int LOCK = 8;
    localparam int MAXR = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_unlock = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        miss_pulse = 1'b0;
    logic [3:0]  mult_cfg;
    logic [1:0]  div_sel;
    logic        detect_off;
    logic        pll_locked;
    logic        limp_active;
    logic [3:0]  ratio_num;
    logic [2:0]  ratio_div;
    logic        over_speed;

    always #10 clk = ~clk;

    pllctl_seq #(.LOCK_CYCLES(LOCK), .MAX_RATIO(MAXR)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .wr_unlock   (wr_unlock),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .miss_pulse  (miss_pulse),
        .mult_cfg    (mult_cfg),
        .div_sel     (div_sel),
        .detect_off  (detect_off),
        .pll_locked  (pll_locked),
        .limp_active (limp_active),
        .ratio_num   (ratio_num),
        .ratio_div   (ratio_div),
        .over_speed  (over_speed)
    );

    typedef struct {
        string      tag;
        logic [3:0] m;
        logic [1:0] ds;
        logic       doff;
        logic       lk;
        logic       lp;
        logic [3:0] num;
        logic [2:0] div;
        logic       ov;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;

    // reference model state
    int mm, md, moff, mlimp, mcnt;

    function automatic exp_t predict(input string tag);
        exp_t e;
        e.tag  = tag;
        e.m    = 4'(mm);
        e.ds   = 2'(md);
        e.doff = 1'(moff);
        e.lp   = 1'(mlimp);
        e.lk   = (mcnt == 0);
        if (mlimp != 0) begin
            e.num = 4'd1; e.div = 3'd2;
        end else if (mcnt != 0) begin
            e.num = 4'd1; e.div = 3'd2;
        end else begin
            e.num = (mm == 0) ? 4'd1 : 4'(mm);
            e.div = (md == 0) ? 3'd4 : (md == 3) ? 3'd1 : 3'd2;
        end
        e.ov = (int'(e.num) > MAXR * int'(e.div));
        return e;
    endfunction

    // monitor: compare one expected item per cycle, away from the active edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if ({mult_cfg, div_sel, detect_off, pll_locked, limp_active, ratio_num, ratio_div, over_speed} !==
                {e.m, e.ds, e.doff, e.lk, e.lp, e.num, e.div, e.ov}) begin
                fails++;
                $display("FAIL %s: actual m=%0d ds=%0d off=%0d lk=%0d lp=%0d ratio=%0d/%0d ov=%0d expected m=%0d ds=%0d off=%0d lk=%0d lp=%0d ratio=%0d/%0d ov=%0d",
                         e.tag, mult_cfg, div_sel, detect_off, pll_locked, limp_active, ratio_num, ratio_div, over_speed,
                         e.m, e.ds, e.doff, e.lk, e.lp, e.num, e.div, e.ov);
            end
        end
    end

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; wr_unlock = 1'b0; miss_pulse = 1'b0;
        @(posedge clk);
        #1;
        mm = 0; md = 0; moff = 0; mlimp = 0; mcnt = 0;
        sb.push_back(predict(tag));
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cycle(input string tag, input logic we, input logic sel,
                         input logic [15:0] data, input logic unl, input logic miss);
        int nm;
        @(negedge clk);
        wr_en = we; wr_sel = sel; wr_data = data; wr_unlock = unl; miss_pulse = miss;
        // model next state from pre-edge values
        nm = int'(data[3:0]);
        if (we && unl && !sel && md == 0 && nm != mm) begin
            mm = nm; mcnt = LOCK;
        end else if (mcnt != 0) begin
            mcnt--;
        end
        if (miss && moff == 0) mlimp = 1;
        if (we && unl && sel) begin
            md = int'(data[8:7]); moff = int'(data[6]);
        end
        @(posedge clk);
        #1;
        wr_en = 1'b0; wr_unlock = 1'b0; miss_pulse = 1'b0;
        sb.push_back(predict(tag));
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) cycle(tag, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0);
    endtask

    initial begin
        mm = 0; md = 0; moff = 0; mlimp = 0; mcnt = 0;
        do_reset("R1");
        cycle("R2", 1'b1, 1'b0, 16'h000A, 1'b0, 1'b0);   // protected write dropped
        cycle("R2", 1'b1, 1'b1, 16'h01C0, 1'b0, 1'b0);
        cycle("R6", 1'b1, 1'b1, 16'h0080, 1'b1, 1'b0);   // dsel=1
        cycle("R3", 1'b1, 1'b0, 16'h000A, 1'b1, 1'b0);   // dropped, dsel!=0
        cycle("R6", 1'b1, 1'b1, 16'h0000, 1'b1, 1'b0);   // dsel=0
        cycle("R4", 1'b1, 1'b0, 16'h000A, 1'b1, 1'b0);   // multiplier 10
        idle("R4", LOCK + 2);
        cycle("R10", 1'b1, 1'b0, 16'h000A, 1'b1, 1'b0);  // same value
        idle("R10", 2);
        cycle("R5", 1'b1, 1'b1, 16'h0080, 1'b1, 1'b0);   // 10/2
        cycle("R5", 1'b1, 1'b1, 16'h0100, 1'b1, 1'b0);   // 10/2
        cycle("R9", 1'b1, 1'b1, 16'h0180, 1'b1, 1'b0);   // 10/1 over
        cycle("R6", 1'b1, 1'b1, 16'h0000, 1'b1, 1'b0);   // 10/4
        cycle("R4", 1'b1, 1'b0, 16'h000C, 1'b1, 1'b0);   // multiplier 12
        idle("R4", 2);
        cycle("R4", 1'b1, 1'b1, 16'h0080, 1'b1, 1'b0);   // dsel during lock
        idle("R9", LOCK);                                // 12/2 over
        cycle("R6", 1'b1, 1'b1, 16'h0000, 1'b1, 1'b0);
        cycle("R5", 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0);   // multiplier 0
        idle("R5", LOCK + 1);
        cycle("R7", 1'b1, 1'b1, 16'h0040, 1'b1, 1'b0);   // detection off
        cycle("R7", 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1);   // pulse ignored
        cycle("R7", 1'b1, 1'b1, 16'h0000, 1'b1, 1'b0);   // detection on
        cycle("R8", 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1);   // limp
        idle("R7", 3);
        cycle("R8", 1'b1, 1'b1, 16'h0180, 1'b1, 1'b0);   // still forced
        cycle("R8", 1'b1, 1'b1, 16'h0000, 1'b1, 1'b0);
        cycle("R8", 1'b1, 1'b0, 16'h0009, 1'b1, 1'b0);
        idle("R8", LOCK + 1);
        do_reset("R1");
        idle("R1", 1);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule